// File: doc/BRIEF.md
# Packed Float-to-Int32 Truncating Converter

This block turns a vector of packed IEEE-754 single-precision values into signed 32-bit integers. Every lane is rounded toward zero, and each lane keeps its bit position. A two-bit mode picks one of three behaviours. The first converts the low four lanes and leaves the upper half of the destination as it was. The second converts the low four lanes and clears the upper half. The third converts all eight lanes.

The surrounding pipeline supplies the source vector and the old destination value. It also supplies a flag saying whether the invalid exception is masked, and the 4-bit reserved specifier field taken from the encoding. One cycle after `in_valid`, the block presents the committed destination, an invalid status, a precision status and an undefined-opcode flag.

A lane is out of range when it is NaN, infinite, at or above 2^31, or below -2^31. With the exception masked, such a lane yields the integer indefinite pattern. With it unmasked, the whole destination is left untouched and the invalid status is still reported.

Top module: `f2i_trunc_vec`

## Requirements
- R1: Each active lane i converts source bits [32i+31:32i] into destination bits [32i+31:32i] as a signed 32-bit integer rounded toward zero; any fraction is dropped.
- R2: `mode` encodes 2'b00 = legacy 4-lane, 2'b01 = zeroing 4-lane, 2'b10 or 2'b11 = 8-lane. The 4-lane modes convert lanes 0..3 only. The 8-lane mode converts lanes 0..7.
- R3: An active lane that is NaN (either sign), ±infinity, at or above 2^31, or below -2^31 sets `flag_inv`. With `inv_masked`=1, that lane yields 32'h8000_0000. An input of exactly -2^31 (32'hCF00_0000) yields 32'h8000_0000 and does not set `flag_inv`.
- R4: `flag_prec` is set when any active, in-range lane drops nonzero fraction bits. Inputs of magnitude below 1.0, including denormals, yield 0 and set precision only when nonzero; -0.0 does not set it.
- R5: In legacy 4-lane mode, destination bits [255:128] equal the old destination's bits [255:128].
- R6: In zeroing 4-lane mode, destination bits [255:128] are zero.
- R7: When `inv_masked`=0 and any active lane is invalid, the whole destination equals `old_dst`, `flag_inv`=1, and `flag_prec` still reports the active lanes.
- R8: In modes 2'b01, 2'b10 and 2'b11, a `spec_field` other than 4'b1111 sets `flag_ud`, keeps the destination equal to `old_dst`, and clears `flag_inv` and `flag_prec`. Legacy mode ignores `spec_field`.
- R9: `flag_inv` and `flag_prec` are the OR over active lanes only; inactive upper lanes never affect them.
- R10: Results, flags and `out_valid` appear one clock after `in_valid`. Without `in_valid`, `dst` holds its value and `out_valid` is 0. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 256 | Packed single-precision source lanes |
| old_dst | input | 256 | Previous destination value |
| mode | input | 2 | Lane-count and upper-half mode |
| inv_masked | input | 1 | 1 = invalid exception masked |
| spec_field | input | 4 | Reserved specifier field to validate |
| out_valid | output | 1 | Result registered this cycle |
| dst | output | 256 | Committed destination |
| flag_inv | output | 1 | Invalid status of the last operation |
| flag_prec | output | 1 | Precision status of the last operation |
| flag_ud | output | 1 | Undefined-opcode flag of the last operation |

## Verification
Every result, including the destination, all three flags and `out_valid`, is due exactly one rising edge after the operation's inputs are sampled. Inputs change on the falling edge. The bench's behavioural model updates its expected outputs on the same rising edge as the design. The comparison runs on the following falling edge, once per clock, and covers idle cycles as well, which confirms that the outputs hold. Directed corner values (±2^31, the largest in-range value, NaN, infinities, denormals, ±0.0, fractions) are mixed with random lanes across all modes, mask settings and specifier values.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    MODE_LEG4  = 2'b00,
    MODE_ZERO4 = 2'b01,
    MODE_FULL8 = 2'b10,
    MODE_FULL8B = 2'b11
  } cvt_mode_e;

  localparam int unsigned LANE_W = 32;
  localparam logic [LANE_W-1:0] INT_INDEF = 32'h8000_0000;
  localparam logic [3:0] SPEC_OK = 4'b1111;
endpackage

// File: rtl/f2i_lane.sv
module f2i_lane
  import f2i_pkg::*;
(
  input  logic [LANE_W-1:0] fp_in,
  output logic [LANE_W-1:0] int_out,
  output logic              lane_inv,
  output logic              lane_inexact
);
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam logic [EXP_W-1:0] BIAS = 8'd127;
  localparam logic [EXP_W-1:0] EXP_LIMIT = 8'd158;
  localparam int WIDE_W = MAN_W + 1 + 31;

  logic                sgn;
  logic [EXP_W-1:0]    ex;
  logic [MAN_W-1:0]    man;
  logic [4:0]          shamt;
  logic [WIDE_W-1:0]   wide;
  logic [LANE_W-1:0]   mag;

  assign sgn = fp_in[31];
  assign ex  = fp_in[30:23];
  assign man = fp_in[22:0];

  always_comb begin
    int_out      = '0;
    lane_inv     = 1'b0;
    lane_inexact = 1'b0;
    shamt        = '0;
    wide         = '0;
    mag          = '0;
    if (ex == 8'hFF) begin
      lane_inv = 1'b1;
    end else if (ex < BIAS) begin
      lane_inexact = |fp_in[30:0];
    end else if (ex >= EXP_LIMIT) begin
      if (sgn && ex == EXP_LIMIT && man == '0) int_out = INT_INDEF;
      else lane_inv = 1'b1;
    end else begin
      shamt        = 5'(ex - BIAS);
      wide         = {31'b0, 1'b1, man} << shamt;
      mag          = wide[WIDE_W-1:MAN_W];
      lane_inexact = |wide[MAN_W-1:0];
      int_out      = sgn ? (~mag + 1'b1) : mag;
    end
    if (lane_inv) int_out = INT_INDEF;
  end
endmodule

// File: rtl/f2i_commit.sv
module f2i_commit
  import f2i_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES*LANE_W-1:0] conv_vec,
  input  logic [LANES-1:0]        lane_inv,
  input  logic [LANES-1:0]        lane_inx,
  input  logic [LANES*LANE_W-1:0] old_dst,
  input  cvt_mode_e               mode,
  input  logic                    inv_masked,
  input  logic [3:0]              spec_field,
  output logic [LANES*LANE_W-1:0] nxt_dst,
  output logic                    nxt_inv,
  output logic                    nxt_prec,
  output logic                    nxt_ud
);
  localparam int VEC_W  = LANES * LANE_W;
  localparam int HALF   = LANES / 2;
  localparam int HALF_W = HALF * LANE_W;

  logic             full_mode;
  logic [LANES-1:0] active;
  logic             red_inv, red_prec;
  logic [VEC_W-1:0] cand;

  assign full_mode = (mode == MODE_FULL8) || (mode == MODE_FULL8B);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_act
      if (i < HALF) begin : g_lo
        assign active[i] = 1'b1;
      end else begin : g_hi
        assign active[i] = full_mode;
      end
    end
  endgenerate

  assign red_inv  = |(lane_inv & active);
  assign red_prec = |(lane_inx & active);

  always_comb begin
    cand[HALF_W-1:0] = conv_vec[HALF_W-1:0];
    unique case (mode)
      MODE_LEG4:  cand[VEC_W-1:HALF_W] = old_dst[VEC_W-1:HALF_W];
      MODE_ZERO4: cand[VEC_W-1:HALF_W] = '0;
      default:    cand[VEC_W-1:HALF_W] = conv_vec[VEC_W-1:HALF_W];
    endcase
  end

  always_comb begin
    nxt_ud   = (mode != MODE_LEG4) && (spec_field != SPEC_OK);
    nxt_dst  = cand;
    nxt_inv  = red_inv;
    nxt_prec = red_prec;
    if (nxt_ud) begin
      nxt_dst  = old_dst;
      nxt_inv  = 1'b0;
      nxt_prec = 1'b0;
    end else if (red_inv && !inv_masked) begin
      nxt_dst = old_dst;
    end
  end
endmodule

// File: rtl/f2i_trunc_vec.sv
module f2i_trunc_vec
  import f2i_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*32-1:0]     src,
  input  logic [LANES*32-1:0]     old_dst,
  input  logic [1:0]              mode,
  input  logic                    inv_masked,
  input  logic [3:0]              spec_field,
  output logic                    out_valid,
  output logic [LANES*32-1:0]     dst,
  output logic                    flag_inv,
  output logic                    flag_prec,
  output logic                    flag_ud
);
  localparam int VEC_W  = LANES * LANE_W;
  localparam int HALF_W = (LANES / 2) * LANE_W;

  logic [VEC_W-1:0] conv_vec;
  logic [LANES-1:0] lane_inv, lane_inx;
  logic [VEC_W-1:0] nxt_dst;
  logic             nxt_inv, nxt_prec, nxt_ud;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      f2i_lane u_lane (
        .fp_in        (src[i*LANE_W +: LANE_W]),
        .int_out      (conv_vec[i*LANE_W +: LANE_W]),
        .lane_inv     (lane_inv[i]),
        .lane_inexact (lane_inx[i])
      );
    end
  endgenerate

  f2i_commit #(.LANES(LANES)) u_commit (
    .conv_vec   (conv_vec),
    .lane_inv   (lane_inv),
    .lane_inx   (lane_inx),
    .old_dst    (old_dst),
    .mode       (cvt_mode_e'(mode)),
    .inv_masked (inv_masked),
    .spec_field (spec_field),
    .nxt_dst    (nxt_dst),
    .nxt_inv    (nxt_inv),
    .nxt_prec   (nxt_prec),
    .nxt_ud     (nxt_ud)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flag_inv  <= 1'b0;
      flag_prec <= 1'b0;
      flag_ud   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst       <= nxt_dst;
        flag_inv  <= nxt_inv;
        flag_prec <= nxt_prec;
        flag_ud   <= nxt_ud;
      end
    end
  end

  assert_ud_keeps_dst_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 2'b00 && spec_field != 4'hF)
      |=> (flag_ud && !flag_inv && !flag_prec && dst == $past(old_dst)));

  assert_legacy_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00)
      |=> (dst[VEC_W-1:HALF_W] == $past(old_dst[VEC_W-1:HALF_W])));

  assert_zero_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01 && spec_field == 4'hF && inv_masked)
      |=> (dst[VEC_W-1:HALF_W] == '0));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dst) && !out_valid));

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

// File: tb/f2i_trunc_vec_tb_top.sv
`timescale 1ns/1ps
module f2i_trunc_vec_tb_top;
  localparam int LANES = 8;
  localparam int VW = LANES * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] src = '0;
  logic [VW-1:0] old_dst = '0;
  logic [1:0]    mode = 2'b00;
  logic          inv_masked = 1'b1;
  logic [3:0]    spec_field = 4'hF;
  logic          out_valid;
  logic [VW-1:0] dst;
  logic          flag_inv, flag_prec, flag_ud;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  f2i_trunc_vec #(.LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .mode(mode), .inv_masked(inv_masked), .spec_field(spec_field),
    .out_valid(out_valid), .dst(dst), .flag_inv(flag_inv),
    .flag_prec(flag_prec), .flag_ud(flag_ud)
  );

  // Behavioural reference of one lane using real arithmetic.
  task automatic ref_lane(input logic [31:0] x, output logic [31:0] r,
                          output bit inv, output bit px);
    real d;
    int  q;
    logic [63:0] b;
    inv = 1'b0; px = 1'b0; r = '0;
    if (x[30:23] == 8'hFF) inv = 1'b1;
    else if (x[30:23] == 8'h00) px = (x[22:0] != 0);
    else begin
      b = {x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'b0};
      d = $bitstoreal(b);
      if (d >= 2147483648.0 || d < -2147483648.0) inv = 1'b1;
      else begin
        q  = $rtoi(d);
        r  = q;
        px = (d != real'(q));
      end
    end
    if (inv) r = 32'h8000_0000;
  endtask

  // Reference model state
  logic          m_valid = 1'b0;
  logic [VW-1:0] m_dst = '0;
  logic          m_inv = 1'b0, m_prec = 1'b0, m_ud = 1'b0;
  logic          m_trap = 1'b0;
  logic [1:0]    m_mode = 2'b00;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_dst = '0; m_inv = 0; m_prec = 0; m_ud = 0; m_trap = 0;
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        automatic int      nl = (mode[1]) ? 8 : 4;
        automatic logic [VW-1:0] cv = '0;
        automatic bit      ai = 0, ap = 0;
        for (int i = 0; i < LANES; i++) begin
          logic [31:0] r; bit li, lp;
          ref_lane(src[i*32 +: 32], r, li, lp);
          cv[i*32 +: 32] = r;
          if (i < nl) begin ai |= li; ap |= lp; end
        end
        m_mode = mode;
        m_trap = 0;
        if (mode != 2'b00 && spec_field != 4'hF) begin
          m_ud = 1; m_inv = 0; m_prec = 0; m_dst = old_dst;
        end else begin
          m_ud = 0; m_inv = ai; m_prec = ap;
          if (ai && !inv_masked) begin m_dst = old_dst; m_trap = 1; end
          else if (mode == 2'b00) m_dst = {old_dst[VW-1:VW/2], cv[VW/2-1:0]};
          else if (mode == 2'b01) m_dst = {{(VW/2){1'b0}}, cv[VW/2-1:0]};
          else m_dst = cv;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    string utag;
    utag = m_ud ? "R8" : m_trap ? "R7" :
           (m_mode == 2'b00) ? "R5" : (m_mode == 2'b01) ? "R6" : "R2";
    chk("R10 out_valid", VW'(out_valid), VW'(m_valid));
    chk(m_ud ? "R8 dst lower" : m_trap ? "R7 dst lower" : "R1 dst lower",
        VW'(dst[VW/2-1:0]), VW'(m_dst[VW/2-1:0]));
    chk({utag, " dst upper"}, VW'(dst[VW-1:VW/2]), VW'(m_dst[VW-1:VW/2]));
    chk("R3/R9 flag_inv", VW'(flag_inv), VW'(m_inv));
    chk("R4/R9 flag_prec", VW'(flag_prec), VW'(m_prec));
    chk("R8 flag_ud", VW'(flag_ud), VW'(m_ud));
  endtask

  localparam int NCORNER = 16;
  function automatic logic [31:0] corner(input int k);
    case (k)
      0:  return 32'h3FC0_0000;  // 1.5
      1:  return 32'hBFC0_0000;  // -1.5
      2:  return 32'h4F00_0000;  // 2^31 -> invalid (R3)
      3:  return 32'hCF00_0000;  // -2^31 exact (R3)
      4:  return 32'h7FC0_0000;  // NaN
      5:  return 32'hFF80_0000;  // -inf
      6:  return 32'h0000_0001;  // denormal (R4)
      7:  return 32'h8000_0000;  // -0.0
      8:  return 32'h3F00_0000;  // 0.5
      9:  return 32'h4E80_0000;  // 2^30
      10: return 32'h4EFF_FFFF;  // largest in range
      11: return 32'hCF00_0001;  // below -2^31
      12: return 32'h7F80_0000;  // +inf
      13: return 32'hFFC0_0001;  // negative NaN
      14: return 32'h4B80_0001;  // 16777218 exact
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] rand_lane();
    int sel = $urandom_range(0, 9);
    if (sel < 3) return corner($urandom_range(0, NCORNER-1));
    return {1'($urandom), 8'($urandom_range(100, 160)), 23'($urandom)};
  endfunction

  task automatic drive_op(input logic [VW-1:0] s, input logic [1:0] md,
                          input logic msk, input logic [3:0] sp);
    src = s; mode = md; inv_masked = msk; spec_field = sp; in_valid = 1'b1;
    for (int i = 0; i < VW/32; i++) old_dst[i*32 +: 32] = $urandom;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 reset dst", dst, '0);
    chk("R10 reset flags", VW'({out_valid, flag_inv, flag_prec, flag_ud}), '0);

    // Directed: each corner placed in lane 0 and lane 5, every mode and mask
    for (int k = 0; k < NCORNER; k++) begin
      for (int md = 0; md < 4; md++) begin
        for (int mk = 0; mk < 2; mk++) begin
          logic [VW-1:0] s = {8{32'h4120_0000}};  // 10.0 elsewhere
          s[31:0]    = corner(k);
          s[191:160] = corner((k + 3) % NCORNER);  // upper lane, R9
          drive_op(s, 2'(md), 1'(mk), 4'hF);
          step();
        end
      end
    end

    // R8: bad specifier in each mode, legacy must ignore it
    for (int md = 0; md < 4; md++) begin
      drive_op({8{32'h3FC0_0000}}, 2'(md), 1'b1, 4'h7);
      step();
    end

    // Idle cycles: outputs hold (R10)
    in_valid = 1'b0;
    repeat (3) step();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) in_valid = 1'b0;
      else begin
        logic [VW-1:0] s;
        for (int i = 0; i < LANES; i++) s[i*32 +: 32] = rand_lane();
        drive_op(s, 2'($urandom), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF);
      end
      step();
    end

    in_valid = 1'b0;
    step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule